// File: doc/BRIEF.md
# Boot-Time Tile Configuration Sequencer

This block lives in the I/O tile of a tiled chip and runs once, before the processors leave reset. Tile identifiers are not fixed at synthesis, so every tile must be told its identifier, and then its register settings, over the one network channel reserved for I/O traffic. No router knows its own coordinates until its tile has been configured. For that reason the sequencer visits the tiles along a serpentine path that starts at the I/O tile, at mesh position (0,0). Each packet therefore goes exactly one hop beyond a tile that is already configured, and its header says which way that hop goes.

Configuration words come from one of two streams: a host-link command stream in normal operation, or a test-pin stream that bypasses a broken host link. The stream is chosen when the sequence starts. After the tile identifiers, the sequencer sends one register packet per register of each tile, then writes the boot program into the local boot memory through a word-write port. Once test mode has been left, it releases the system reset. It then idles until the first CPU request arrives and reports completion. Every network write waits for a one-flit acknowledgement. If an acknowledgement does not arrive in time, the sequence halts with an error flag set.

Top module: `tile_boot_seq`

## Requirements
- R1: While rst_n is low, and after it has been released, until start_i: noc_valid_o, sys_rst_n_o, done_o, err_o, boot_we_o, host_ready_o and tpin_ready_o are all 0.
- R2: The first NTILES packets set the tile identifiers, one packet per tile in serpentine order. Each packet is two flits: a header and then a data flit. The header has opcode 01 in bits [DATA_W-1:DATA_W-2] and the tile's row-major identifier y*MESH_X+x in bits [ID_W-1:0]. The data flit holds that same identifier. Tile index k lies in row k/MESH_X, at column k%MESH_X on even rows and MESH_X-1-k%MESH_X on odd rows.
- R3: Header bits [DATA_W-3:DATA_W-4] give the hop direction from the previous tile on the path. The value is 0 (local) for index 0, 3 (south) for the first tile of each later row, 1 (east) for the other tiles of even rows and 2 (west) for the other tiles of odd rows.
- R4: A flit offered with noc_ready_i low stays offered and unchanged. No header flit of a new packet is sent before ack_valid_i has acknowledged the data flit of the previous packet.
- R5: After the identifier packets come REGS_PER_TILE register packets per tile, in the same tile order and in ascending register index. Each header has opcode 10, the hop and identifier fields of R2 and R3, and the register index in bits [ID_W+RIX_W-1:ID_W]. The data flit is the next word of the selected source.
- R6: After the register packets, BOOT_WORDS source words are written through boot_we_o to ascending addresses from 0, one write per accepted word, with no flit offered while a write is made.
- R7: src_sel_i is latched on start_i (0 selects the host stream, 1 the test-pin stream). Only the selected stream ever sees its ready signal high, and words from the other stream never reach the network or the boot memory.
- R8: sys_rst_n_o stays low until the last boot word is written and test_mode_i is low. It rises one cycle after test_mode_i is sampled low in that phase and stays high from then on.
- R9: With the reset released, done_o rises in the cycle after cpu_req_i is first sampled high, and not before.
- R10: If no acknowledgement arrives for TIMEOUT cycles after a data flit is accepted, err_o rises at the TIMEOUT-th clock edge after the acceptance edge and stays high. From then on no flit is offered and sys_rst_n_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts the sequence (sampled in idle) |
| src_sel_i | input | 1 | Source select: 0 host stream, 1 test pins |
| test_mode_i | input | 1 | High while the chip is in test mode |
| host_valid_i | input | 1 | Host stream word valid |
| host_ready_o | output | 1 | Host stream word taken |
| host_data_i | input | DATA_W | Host stream word |
| tpin_valid_i | input | 1 | Test-pin stream word valid |
| tpin_ready_o | output | 1 | Test-pin stream word taken |
| tpin_data_i | input | DATA_W | Test-pin stream word |
| noc_valid_o | output | 1 | Flit valid on the configuration channel |
| noc_ready_i | input | 1 | Channel accepts the flit |
| noc_flit_o | output | DATA_W | Flit on the configuration channel |
| ack_valid_i | input | 1 | One-cycle acknowledgement from the target tile |
| boot_we_o | output | 1 | Boot memory write enable |
| boot_addr_o | output | BIX_W | Boot memory word address |
| boot_wdata_o | output | DATA_W | Boot memory write data |
| sys_rst_n_o | output | 1 | System reset to the rest of the chip, active low |
| cpu_req_i | input | 1 | First request from the CPU tile |
| done_o | output | 1 | Boot handed over to the CPU |
| err_o | output | 1 | Acknowledgement timeout, sequence halted |

## Verification
On every cycle the assertions check that a stalled flit holds steady, that both source streams are never taken together, and that the reset rises only outside test mode and never falls again. They also check that completion follows a CPU request, that the error flag is sticky and silences the channel, and that a timeout fires only after a full window without an acknowledgement. Only the bench scenarios can show the serpentine order with its identifiers and hop codes, the packet-per-acknowledgement pacing under random back-pressure and acknowledgement delays, the register and boot-word ordering, the source latching with the other stream driving junk, and the exact cycle in which a withheld acknowledgement turns into the error flag.

// File: rtl/tbseq_pkg.sv
package tbseq_pkg;

  typedef enum logic [1:0] {
    HOP_LOCAL = 2'd0,
    HOP_EAST  = 2'd1,
    HOP_WEST  = 2'd2,
    HOP_SOUTH = 2'd3
  } hop_e;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_TILE_ID = 2'd1,
    OP_REG     = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CFG_TILES,
    S_CFG_REGS,
    S_LOAD_BOOT,
    S_RELEASE,
    S_WAIT_CPU,
    S_FINISHED,
    S_HALT
  } seq_st_e;

  // Column of the k-th tile on the serpentine path (even rows run east).
  function automatic int unsigned walk_col(int unsigned k, int unsigned mx);
    int unsigned row;
    int unsigned pos;
    row = k / mx;
    pos = k % mx;
    return (row % 2 == 0) ? pos : (mx - 1 - pos);
  endfunction

  // Row-major identifier of the k-th tile on the path.
  function automatic int unsigned walk_id(int unsigned k, int unsigned mx);
    return (k / mx) * mx + walk_col(k, mx);
  endfunction

  // Direction of the hop from path tile k-1 to path tile k.
  function automatic logic [1:0] walk_hop(int unsigned k, int unsigned mx);
    if (k == 0) return HOP_LOCAL;
    if (k % mx == 0) return HOP_SOUTH;
    if ((k / mx) % 2 == 0) return HOP_EAST;
    return HOP_WEST;
  endfunction

endpackage

// File: rtl/tbseq_src_mux.sv
module tbseq_src_mux #(
  parameter int DATA_W = 16
) (
  input  logic              sel_i,
  input  logic              host_valid_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              tpin_valid_i,
  input  logic [DATA_W-1:0] tpin_data_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              host_ready_o,
  output logic              tpin_ready_o
);
  always_comb begin
    valid_o      = sel_i ? tpin_valid_i : host_valid_i;
    data_o       = sel_i ? tpin_data_i  : host_data_i;
    host_ready_o = take_i && !sel_i;
    tpin_ready_o = take_i &&  sel_i;
  end
endmodule

// File: rtl/tbseq_tile_walker.sv
module tbseq_tile_walker
  import tbseq_pkg::*;
#(
  parameter int MESH_X = 3,
  parameter int MESH_Y = 2,
  localparam int NTILES = MESH_X * MESH_Y,
  localparam int ID_W   = (NTILES > 1) ? $clog2(NTILES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic            last_o,
  output logic [1:0]      hop_o,
  output logic [ID_W-1:0] tid_o
);
  logic [ID_W-1:0] idx_q;

  assign last_o = (idx_q == ID_W'(NTILES - 1));
  assign hop_o  = walk_hop(32'(idx_q), MESH_X);
  assign tid_o  = ID_W'(walk_id(32'(idx_q), MESH_X));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= last_o ? '0 : idx_q + ID_W'(1);
    end
  end
endmodule

// File: rtl/tbseq_pkt_tx.sv
module tbseq_pkt_tx #(
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 40,
  localparam int CNT_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [DATA_W-1:0] hdr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              idle_o,
  output logic              noc_valid_o,
  input  logic              noc_ready_i,
  output logic [DATA_W-1:0] noc_flit_o,
  input  logic              ack_i,
  output logic              ev_data_sent_o,
  output logic              ev_done_o,
  output logic              ev_timeout_o
);
  typedef enum logic [1:0] {P_IDLE, P_HDR, P_DAT, P_ACK} pst_e;

  pst_e              st_q;
  logic [DATA_W-1:0] hdr_q;
  logic [DATA_W-1:0] dat_q;
  logic [CNT_W-1:0]  cnt_q;

  assign idle_o         = (st_q == P_IDLE);
  assign noc_valid_o    = (st_q == P_HDR) || (st_q == P_DAT);
  assign noc_flit_o     = (st_q == P_HDR) ? hdr_q : dat_q;
  assign ev_data_sent_o = (st_q == P_DAT) && noc_ready_i;
  assign ev_done_o      = (st_q == P_ACK) && ack_i;
  assign ev_timeout_o   = (st_q == P_ACK) && !ack_i && (cnt_q == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= P_IDLE;
      hdr_q <= '0;
      dat_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        P_IDLE: if (go_i) begin
          hdr_q <= hdr_i;
          dat_q <= data_i;
          st_q  <= P_HDR;
        end
        P_HDR: if (noc_ready_i) st_q <= P_DAT;
        P_DAT: if (noc_ready_i) begin
          st_q  <= P_ACK;
          cnt_q <= '0;
        end
        P_ACK: begin
          if (ev_done_o || ev_timeout_o) st_q <= P_IDLE;
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_boot_seq.sv
module tile_boot_seq
  import tbseq_pkg::*;
#(
  parameter int MESH_X        = 3,
  parameter int MESH_Y        = 2,
  parameter int REGS_PER_TILE = 2,
  parameter int BOOT_WORDS    = 4,
  parameter int DATA_W        = 16,
  parameter int TIMEOUT       = 40,
  localparam int NTILES = MESH_X * MESH_Y,
  localparam int ID_W   = (NTILES > 1) ? $clog2(NTILES) : 1,
  localparam int RIX_W  = (REGS_PER_TILE > 1) ? $clog2(REGS_PER_TILE) : 1,
  localparam int BIX_W  = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              src_sel_i,
  input  logic              test_mode_i,
  input  logic              host_valid_i,
  output logic              host_ready_o,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              tpin_valid_i,
  output logic              tpin_ready_o,
  input  logic [DATA_W-1:0] tpin_data_i,
  output logic              noc_valid_o,
  input  logic              noc_ready_i,
  output logic [DATA_W-1:0] noc_flit_o,
  input  logic              ack_valid_i,
  output logic              boot_we_o,
  output logic [BIX_W-1:0]  boot_addr_o,
  output logic [DATA_W-1:0] boot_wdata_o,
  output logic              sys_rst_n_o,
  input  logic              cpu_req_i,
  output logic              done_o,
  output logic              err_o
);
  seq_st_e           st_q;
  logic              sel_q;
  logic [RIX_W-1:0]  ridx_q;
  logic [BIX_W-1:0]  bidx_q;
  logic              rel_q;
  logic              done_q;
  logic              err_q;

  // named internal events, also used by the bound checker
  logic              src_valid;
  logic [DATA_W-1:0] src_data;
  logic              src_take;
  logic              tx_idle;
  logic              tx_go;
  logic              ev_data_sent;
  logic              ev_pkt_done;
  logic              ev_timeout;
  logic              walk_adv;
  logic              walk_last;
  logic [1:0]        walk_hop_dir;
  logic [ID_W-1:0]   walk_tid;
  logic              last_reg;
  logic [DATA_W-1:0] pkt_hdr;
  logic [DATA_W-1:0] pkt_data;

  tbseq_src_mux #(.DATA_W(DATA_W)) u_src (
    .sel_i        (sel_q),
    .host_valid_i (host_valid_i),
    .host_data_i  (host_data_i),
    .tpin_valid_i (tpin_valid_i),
    .tpin_data_i  (tpin_data_i),
    .take_i       (src_take),
    .valid_o      (src_valid),
    .data_o       (src_data),
    .host_ready_o (host_ready_o),
    .tpin_ready_o (tpin_ready_o)
  );

  tbseq_tile_walker #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (st_q == S_IDLE),
    .adv_i  (walk_adv),
    .last_o (walk_last),
    .hop_o  (walk_hop_dir),
    .tid_o  (walk_tid)
  );

  tbseq_pkt_tx #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_tx (
    .clk            (clk),
    .rst_n          (rst_n),
    .go_i           (tx_go),
    .hdr_i          (pkt_hdr),
    .data_i         (pkt_data),
    .idle_o         (tx_idle),
    .noc_valid_o    (noc_valid_o),
    .noc_ready_i    (noc_ready_i),
    .noc_flit_o     (noc_flit_o),
    .ack_i          (ack_valid_i),
    .ev_data_sent_o (ev_data_sent),
    .ev_done_o      (ev_pkt_done),
    .ev_timeout_o   (ev_timeout)
  );

  assign last_reg = (ridx_q == RIX_W'(REGS_PER_TILE - 1));

  always_comb begin
    src_take = ((st_q == S_CFG_REGS) && tx_idle && src_valid) ||
               ((st_q == S_LOAD_BOOT) && src_valid);
    tx_go    = ((st_q == S_CFG_TILES) && tx_idle) ||
               ((st_q == S_CFG_REGS) && tx_idle && src_valid);
    walk_adv = ev_pkt_done &&
               ((st_q == S_CFG_TILES) || ((st_q == S_CFG_REGS) && last_reg));

    pkt_hdr = '0;
    pkt_hdr[DATA_W-1 -: 2] = (st_q == S_CFG_TILES) ? OP_TILE_ID : OP_REG;
    pkt_hdr[DATA_W-3 -: 2] = walk_hop_dir;
    pkt_hdr[ID_W +: RIX_W] = (st_q == S_CFG_REGS) ? ridx_q : '0;
    pkt_hdr[ID_W-1:0]      = walk_tid;
    pkt_data = (st_q == S_CFG_TILES) ? DATA_W'(walk_tid) : src_data;
  end

  assign boot_we_o    = (st_q == S_LOAD_BOOT) && src_valid;
  assign boot_addr_o  = bidx_q;
  assign boot_wdata_o = src_data;
  assign sys_rst_n_o  = rel_q;
  assign done_o       = done_q;
  assign err_o        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sel_q  <= 1'b0;
      ridx_q <= '0;
      bidx_q <= '0;
      rel_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (ev_timeout) begin
      st_q  <= S_HALT;
      err_q <= 1'b1;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          sel_q  <= src_sel_i;
          ridx_q <= '0;
          bidx_q <= '0;
          st_q   <= S_CFG_TILES;
        end
        S_CFG_TILES: if (ev_pkt_done && walk_last) st_q <= S_CFG_REGS;
        S_CFG_REGS: if (ev_pkt_done) begin
          ridx_q <= last_reg ? '0 : ridx_q + RIX_W'(1);
          if (last_reg && walk_last) st_q <= S_LOAD_BOOT;
        end
        S_LOAD_BOOT: if (src_valid) begin
          bidx_q <= bidx_q + BIX_W'(1);
          if (bidx_q == BIX_W'(BOOT_WORDS - 1)) st_q <= S_RELEASE;
        end
        S_RELEASE: if (!test_mode_i) begin
          rel_q <= 1'b1;
          st_q  <= S_WAIT_CPU;
        end
        S_WAIT_CPU: if (cpu_req_i) begin
          done_q <= 1'b1;
          st_q   <= S_FINISHED;
        end
        S_FINISHED: st_q <= S_FINISHED;
        S_HALT:     st_q <= S_HALT;
        default:    st_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/tile_boot_seq_chk.sv
module tile_boot_seq_chk #(
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              noc_valid,
  input logic              noc_ready,
  input logic [DATA_W-1:0] noc_flit,
  input logic              host_ready,
  input logic              tpin_ready,
  input logic              test_mode,
  input logic              sys_rst_n,
  input logic              cpu_req,
  input logic              done,
  input logic              err,
  input logic              boot_we,
  input logic              ev_data_sent,
  input logic              ev_timeout
);
  // cycles spent waiting since the last accepted data flit
  logic [31:0] wait_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (ev_data_sent) wait_cnt <= '0;
    else if (wait_cnt != 32'hFFFF_FFFF) wait_cnt <= wait_cnt + 32'd1;
  end

  p_hold_flit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (noc_valid && !noc_ready) |=> (noc_valid && $stable(noc_flit)));

  p_boot_quiet_net_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_we |-> !noc_valid);

  p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ready && tpin_ready));

  p_release_outside_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(!test_mode));

  p_release_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |=> sys_rst_n);

  p_done_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cpu_req) && sys_rst_n));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!noc_valid && !sys_rst_n && !done));

  p_timeout_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> (wait_cnt >= 32'(TIMEOUT - 1)));
endmodule

bind tile_boot_seq tile_boot_seq_chk #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .noc_valid    (noc_valid_o),
  .noc_ready    (noc_ready_i),
  .noc_flit     (noc_flit_o),
  .host_ready   (host_ready_o),
  .tpin_ready   (tpin_ready_o),
  .test_mode    (test_mode_i),
  .sys_rst_n    (sys_rst_n_o),
  .cpu_req      (cpu_req_i),
  .done         (done_o),
  .err          (err_o),
  .boot_we      (boot_we_o),
  .ev_data_sent (ev_data_sent),
  .ev_timeout   (ev_timeout)
);

// File: tb/sim_tile_boot_seq.sv
`timescale 1ns/1ps
module sim_tile_boot_seq;
  localparam int MX = 3;
  localparam int MY = 2;
  localparam int RG = 2;
  localparam int BW = 4;
  localparam int DW = 16;
  localparam int TO = 40;
  localparam int NT = MX * MY;
  localparam int NW = NT * RG + BW;
  localparam int BXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, src_sel_i = 1'b0, test_mode_i = 1'b1;
  logic host_valid_i = 1'b0, tpin_valid_i = 1'b0;
  logic host_ready_o, tpin_ready_o;
  logic [DW-1:0] host_data_i = '0, tpin_data_i = '0;
  logic noc_valid_o, noc_ready_i = 1'b0;
  logic [DW-1:0] noc_flit_o;
  logic ack_valid_i = 1'b0;
  logic boot_we_o;
  logic [BXW-1:0] boot_addr_o;
  logic [DW-1:0] boot_wdata_o;
  logic sys_rst_n_o, cpu_req_i = 1'b0, done_o, err_o;

  always #2.5 clk = ~clk;

  tile_boot_seq #(.MESH_X(MX), .MESH_Y(MY), .REGS_PER_TILE(RG), .BOOT_WORDS(BW),
                  .DATA_W(DW), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_sel_i(src_sel_i),
    .test_mode_i(test_mode_i),
    .host_valid_i(host_valid_i), .host_ready_o(host_ready_o), .host_data_i(host_data_i),
    .tpin_valid_i(tpin_valid_i), .tpin_ready_o(tpin_ready_o), .tpin_data_i(tpin_data_i),
    .noc_valid_o(noc_valid_o), .noc_ready_i(noc_ready_i), .noc_flit_o(noc_flit_o),
    .ack_valid_i(ack_valid_i),
    .boot_we_o(boot_we_o), .boot_addr_o(boot_addr_o), .boot_wdata_o(boot_wdata_o),
    .sys_rst_n_o(sys_rst_n_o), .cpu_req_i(cpu_req_i), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected model, written from the requirements
  function automatic int b_id(int k);
    int row = k / MX;
    int pos = k - row * MX;
    return row * MX + ((row & 1) ? (MX - 1 - pos) : pos);
  endfunction

  function automatic int b_hop(int k);
    if (k == 0) return 0;
    if (k % MX == 0) return 3;
    return ((k / MX) & 1) ? 2 : 1;
  endfunction

  function automatic logic [DW-1:0] b_hdr(int op, int hop, int ridx, int id);
    return DW'((op << 14) | (hop << 12) | (ridx << 3) | id);
  endfunction

  // bench state
  logic [DW-1:0] exp_f[$];
  logic [DW-1:0] words[NW];
  bit   run_sel;
  bit   mon_en = 0;
  int   cyc = 0;
  int   fi, wi, bi, drop, drop_cyc, ack_dly;
  bit   s_hold, ack_wait, awaiting, prev_stall, bad_sel;
  logic [DW-1:0] prev_flit;

  always @(negedge clk) begin
    cyc++;
    ack_valid_i = 1'b0;
    if (!mon_en) begin
      noc_ready_i = 1'b0;
    end else begin
      if (ack_wait) begin
        if (ack_dly == 0) begin
          ack_valid_i = 1'b1; ack_wait = 0; awaiting = 0;
        end else ack_dly--;
      end
      if (prev_stall) chk("R4 stalled flit held", {15'd0, noc_valid_o, noc_flit_o},
                          {15'd0, 1'b1, prev_flit});
      noc_ready_i = ($urandom % 4) != 0;
      if (!s_hold && wi < NW && ($urandom % 10) < 7) s_hold = 1;
      if (run_sel) begin
        tpin_valid_i = s_hold; tpin_data_i = words[wi < NW ? wi : 0];
        host_valid_i = 1'b1;   host_data_i = 16'hBAD0;
      end else begin
        host_valid_i = s_hold; host_data_i = words[wi < NW ? wi : 0];
        tpin_valid_i = 1'b1;   tpin_data_i = 16'hBAD1;
      end
      #1;
      prev_stall = noc_valid_o && !noc_ready_i;
      prev_flit  = noc_flit_o;
      if (noc_valid_o && noc_ready_i) begin
        if ((fi % 2) == 0 && awaiting) chk("R4 header before ack", 1, 0);
        if (fi < exp_f.size()) begin
          if ((fi % 2) == 0) chk("R3 hop field", 32'(noc_flit_o[13:12]), 32'(exp_f[fi][13:12]));
          chk(fi < 2 * NT ? "R2 tile id flit" : "R5 register flit",
              32'(noc_flit_o), 32'(exp_f[fi]));
        end else chk("R6 extra flit", 1, 0);
        if ((fi % 2) == 1) begin
          if (fi / 2 != drop) begin ack_wait = 1; ack_dly = $urandom % 5; end
          else drop_cyc = cyc;
          awaiting = 1;
        end
        fi++;
      end
      if (s_hold && (run_sel ? tpin_ready_o : host_ready_o)) begin
        s_hold = 0; wi++;
      end
      if (run_sel ? host_ready_o : tpin_ready_o) bad_sel = 1;
      if (boot_we_o) begin
        chk("R6 boot addr", 32'(boot_addr_o), 32'(bi));
        chk("R6 boot data", 32'(boot_wdata_o), 32'(words[NT * RG + (bi < BW ? bi : 0)]));
        chk("R6 no flit during write", 32'(noc_valid_o), 0);
        bi++;
      end
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic run(input bit sel, input int dropk);
    bit flag;
    mon_en = 0; rst_n = 0; start_i = 0; cpu_req_i = 0; test_mode_i = 1;
    host_valid_i = 0; tpin_valid_i = 0;
    fi = 0; wi = 0; bi = 0; drop = dropk; drop_cyc = -1; ack_dly = 0;
    s_hold = 0; ack_wait = 0; awaiting = 0; prev_stall = 0; bad_sel = 0;
    run_sel = sel;
    for (int i = 0; i < NW; i++) words[i] = DW'($urandom);
    exp_f.delete();
    for (int k = 0; k < NT; k++) begin
      exp_f.push_back(b_hdr(1, b_hop(k), 0, b_id(k)));
      exp_f.push_back(DW'(b_id(k)));
    end
    for (int k = 0; k < NT; k++)
      for (int r = 0; r < RG; r++) begin
        exp_f.push_back(b_hdr(2, b_hop(k), r, b_id(k)));
        exp_f.push_back(words[k * RG + r]);
      end
    repeat (2) tick();
    chk("R1 reset noc_valid", 32'(noc_valid_o), 0);
    chk("R1 reset sys_rst_n", 32'(sys_rst_n_o), 0);
    rst_n = 1;
    tick();
    chk("R1 idle outputs", {26'd0, noc_valid_o, sys_rst_n_o, done_o, err_o, boot_we_o, 1'b0}, 0);
    host_valid_i = 1; tpin_valid_i = 1; #1;
    chk("R1 idle readies", {30'd0, host_ready_o, tpin_ready_o}, 0);
    host_valid_i = 0; tpin_valid_i = 0;
    tick();
    src_sel_i = sel; start_i = 1;
    tick();
    start_i = 0; src_sel_i = !sel; mon_en = 1;
    if (dropk >= 0) begin
      for (int g = 0; g < 5000 && drop_cyc < 0; g++) tick();
      while (cyc < drop_cyc + TO) tick();
      chk("R10 err before window end", 32'(err_o), 0);
      tick();
      chk("R10 err at window end", 32'(err_o), 1);
      chk("R10 flits when halted", 32'(fi), 32'(2 * (dropk + 1)));
      flag = 0;
      for (int g = 0; g < 20; g++) begin
        tick();
        if (noc_valid_o || sys_rst_n_o || !err_o) flag = 1;
      end
      chk("R10 halted quiet", 32'(flag), 0);
    end else begin
      for (int g = 0; g < 20000 && bi < BW; g++) tick();
      chk("R5 all flits sent", 32'(fi), 32'(exp_f.size()));
      chk("R6 all boot words", 32'(bi), BW);
      flag = 0;
      for (int g = 0; g < 8; g++) begin tick(); if (sys_rst_n_o) flag = 1; end
      chk("R8 reset held in test mode", 32'(flag), 0);
      test_mode_i = 0;
      tick();
      chk("R8 reset released", 32'(sys_rst_n_o), 1);
      flag = 0;
      for (int g = 0; g < 5; g++) begin tick(); if (done_o) flag = 1; end
      chk("R9 no done before request", 32'(flag), 0);
      cpu_req_i = 1;
      tick();
      cpu_req_i = 0;
      chk("R9 done after request", 32'(done_o), 1);
      tick();
      chk("R8 reset stays released", 32'(sys_rst_n_o), 1);
    end
    chk("R7 unselected source never ready", 32'(bad_sel), 0);
    mon_en = 0;
    tick();
  endtask

  initial begin
    void'($urandom(32'd1357));
    run(1'b0, -1);
    run(1'b1, -1);
    run(1'b0, 2);
    run(1'b1, NT + 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule